// File: doc/BRIEF.md
# CAN Controller Interrupt Flag and Source Code Unit

This block is the interrupt section of a CAN controller. It keeps two 8-bit registers: an enable register and a flag register. Each of the eight interrupt sources sets its own flag with a one-cycle event pulse. A set flag stays set until host software clears it through the register port. An active-low interrupt pin is asserted whenever a flagged source is also enabled.

A fixed-priority encoder reduces the enabled pending sources to a 3-bit source code. Software reads that code from a status register, along with the controller's 3-bit operating mode, which arrives on an input. The host reaches the registers through a simple port with three kinds of access: a full write, a masked bit-modify, and a read. Decoding the serial command stream into these accesses is done outside this block, as is the generation of the event pulses.

Top module: `canirq_unit`

## Requirements
- R1: After reset, the enable and flag registers are 0x00, `irqN` is 1 and `irqCode` is 000.
- R2: A write (`regWr`=1, `regMod`=0) to `ADDR_ENABLE` (default 0x01) or `ADDR_FLAG` (default 0x02) replaces that register with `regWdata` at the next clock edge. Both registers use the same bit per source: 7 message error, 6 wake-up, 5 error, 4 TX2 empty, 3 TX1 empty, 2 TX0 empty, 1 RX1 full, 0 RX0 full. Event input `evtPulse` uses the same bit order.
- R3: An access with `regMod`=1 is a bit-modify: the addressed register becomes (old & ~regMask) | (regWdata & regMask). A bit-modify takes precedence over `regWr`.
- R4: A high `evtPulse` bit sets the matching flag at the next edge. The flag then stays 1 until a host write or bit-modify clears it.
- R5: If an event pulse and a host clear reach the same flag in the same cycle, the flag ends up 1.
- R6: `irqN` is 0 exactly when some bit is 1 in both the flag register and the enable register.
- R7: `irqCode` names the highest-priority source that is both flagged and enabled. The order from highest to lowest, with codes, is: error=001, wake-up=010, TX0=011, TX1=100, TX2=101, RX0=110, RX1=111. The code is 000 when none of these is both flagged and enabled; the message-error source has no code of its own.
- R8: A read of `ADDR_STATUS` (default 0x00) returns {opMode, 0, irqCode, 0}: the mode in bits [7:5], the code in bits [3:1], and 0 in bits 4 and 0.
- R9: Reads of the enable and flag addresses return the register contents. `regRdata` is 0x00 when `regRd` is 0 or the address is unmapped.
- R10: Writes and bit-modifies to `ADDR_STATUS` or to unmapped addresses change neither the enable register nor the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 8 | One-cycle event pulses, one per source |
| regAddr | input | ADDR_W | Register address |
| regWr | input | 1 | Full write strobe |
| regMod | input | 1 | Bit-modify strobe |
| regRd | input | 1 | Read enable |
| regWdata | input | 8 | Write / modify data |
| regMask | input | 8 | Bit-modify mask |
| opMode | input | 3 | Operating mode shown in the status register |
| regRdata | output | 8 | Read data |
| irqN | output | 1 | Interrupt pin, active low |
| irqCode | output | 3 | Highest-priority enabled pending source |

## Verification
Two functions can hit the flag register in the same cycle: the setting of a flag by an event pulse, and a host write or bit-modify that clears the same flag. The bench forces this directly by writing zero to a set flag while pulsing its event. It also produces the collision at random, by mixing sparse event pulses with write and modify accesses on the flag address. Each outcome is judged against a bench model in which the event term is OR'd in after the host update, and the flag, pin and code are compared one cycle later.

// File: rtl/canirq_pkg.sv
package canirq_pkg;
  localparam int SRC_N  = 8;
  localparam int CODE_W = 3;
  localparam int MODE_W = 3;

  // source bit positions (shared by enables, flags and event pulses)
  localparam int SRC_MERR = 7;
  localparam int SRC_WAKE = 6;
  localparam int SRC_ERR  = 5;
  localparam int SRC_TX2  = 4;
  localparam int SRC_TX1  = 3;
  localparam int SRC_TX0  = 2;
  localparam int SRC_RX1  = 1;
  localparam int SRC_RX0  = 0;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_ENABLE = 2'd1,
    RD_FLAG   = 2'd2,
    RD_STATUS = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   enLoad;
    logic   flLoad;
    logic   modify;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/canirq_ctrl.sv
module canirq_ctrl
  import canirq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int ADDR_STATUS = 0,
  parameter int ADDR_ENABLE = 1,
  parameter int ADDR_FLAG   = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regMod,
  input  logic              regRd,
  output regStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] AEN = ADDR_W'(ADDR_ENABLE);
  localparam logic [ADDR_W-1:0] AFL = ADDR_W'(ADDR_FLAG);
  localparam logic [ADDR_W-1:0] AST = ADDR_W'(ADDR_STATUS);

  logic access;
  assign access = regWr | regMod;

  always_comb begin
    stb.enLoad = access && (regAddr == AEN);
    stb.flLoad = access && (regAddr == AFL);
    stb.modify = regMod;
    stb.rdSel  = RD_NONE;
    if (regRd) begin
      if (regAddr == AEN)      stb.rdSel = RD_ENABLE;
      else if (regAddr == AFL) stb.rdSel = RD_FLAG;
      else if (regAddr == AST) stb.rdSel = RD_STATUS;
    end
  end
endmodule

// File: rtl/canirq_regs.sv
module canirq_regs
  import canirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [SRC_N-1:0]  evtPulse,
  input  logic [SRC_N-1:0]  regWdata,
  input  logic [SRC_N-1:0]  regMask,
  input  logic [MODE_W-1:0] opMode,
  input  logic [CODE_W-1:0] irqCode,
  output logic [SRC_N-1:0]  enables,
  output logic [SRC_N-1:0]  flags,
  output logic [SRC_N-1:0]  regRdata
);
  logic [SRC_N-1:0] enNext, flHost, flNext;

  function automatic logic [SRC_N-1:0] applyAccess(
    input logic [SRC_N-1:0] oldV, input logic [SRC_N-1:0] dataV,
    input logic [SRC_N-1:0] maskV, input logic useMask);
    applyAccess = useMask ? ((oldV & ~maskV) | (dataV & maskV)) : dataV;
  endfunction

  always_comb begin
    enNext = stb.enLoad ? applyAccess(enables, regWdata, regMask, stb.modify) : enables;
    flHost = stb.flLoad ? applyAccess(flags, regWdata, regMask, stb.modify) : flags;
    flNext = flHost | evtPulse;   // event beats a host clear
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enables <= '0;
      flags   <= '0;
    end else begin
      enables <= enNext;
      flags   <= flNext;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_ENABLE: regRdata = enables;
      RD_FLAG:   regRdata = flags;
      RD_STATUS: regRdata = {opMode, 1'b0, irqCode, 1'b0};
      default:   regRdata = '0;
    endcase
  end

  // flags only drop through a host access to the flag register
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.flLoad |=> ((flags & $past(flags)) == $past(flags)));

  // a pulsed event is always present one cycle later, clear or not
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((flags & $past(evtPulse)) == $past(evtPulse)));

  // bit-modify leaves unmasked enable bits untouched
  assert_modify_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enLoad && stb.modify) |=> (((enables ^ $past(enables)) & ~$past(regMask)) == '0));

  // enables move only on an access aimed at them
  assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.enLoad |=> $stable(enables));
endmodule

// File: rtl/canirq_prio.sv
module canirq_prio
  import canirq_pkg::*;
(
  input  logic [SRC_N-1:0]  pending,
  output logic [CODE_W-1:0] irqCode
);
  always_comb begin
    if (pending[SRC_ERR])       irqCode = 3'b001;
    else if (pending[SRC_WAKE]) irqCode = 3'b010;
    else if (pending[SRC_TX0])  irqCode = 3'b011;
    else if (pending[SRC_TX1])  irqCode = 3'b100;
    else if (pending[SRC_TX2])  irqCode = 3'b101;
    else if (pending[SRC_RX0])  irqCode = 3'b110;
    else if (pending[SRC_RX1])  irqCode = 3'b111;
    else                        irqCode = 3'b000;
  end
endmodule

// File: rtl/canirq_unit.sv
module canirq_unit
  import canirq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int ADDR_STATUS = 0,
  parameter int ADDR_ENABLE = 1,
  parameter int ADDR_FLAG   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        evtPulse,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regMod,
  input  logic              regRd,
  input  logic [7:0]        regWdata,
  input  logic [7:0]        regMask,
  input  logic [2:0]        opMode,
  output logic [7:0]        regRdata,
  output logic              irqN,
  output logic [2:0]        irqCode
);
  regStrobe_t       stb;
  logic [SRC_N-1:0] enables, flags, pending;

  canirq_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_STATUS(ADDR_STATUS),
    .ADDR_ENABLE(ADDR_ENABLE), .ADDR_FLAG(ADDR_FLAG)
  ) i_ctrl (
    .regAddr(regAddr), .regWr(regWr), .regMod(regMod), .regRd(regRd), .stb(stb)
  );

  canirq_regs i_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .evtPulse(evtPulse),
    .regWdata(regWdata), .regMask(regMask), .opMode(opMode),
    .irqCode(irqCode), .enables(enables), .flags(flags), .regRdata(regRdata)
  );

  assign pending = flags & enables;
  assign irqN    = ~(|pending);

  canirq_prio i_prio (.pending(pending), .irqCode(irqCode));

  // a nonzero code implies the pin is asserted
  assert_code_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqCode != 3'b000) |-> !irqN);

  // pin asserted with code 000 only for the codeless message-error source
  assert_pin_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && irqCode == 3'b000) |-> (flags[SRC_MERR] && enables[SRC_MERR]));

  // nothing enabled means no interrupt
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enables == '0) |-> irqN);
endmodule

// File: tb/test_canirq_unit.sv
module test_canirq_unit;
  localparam logic [7:0] A_ST = 8'h00, A_EN = 8'h01, A_FL = 8'h02;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] evtPulse = '0, regAddr = '0, regWdata = '0, regMask = '0;
  logic regWr = 1'b0, regMod = 1'b0, regRd = 1'b0;
  logic [2:0] opMode = '0;
  logic [7:0] regRdata;
  logic irqN;
  logic [2:0] irqCode;

  int checks = 0, errors = 0;
  logic [7:0] mEn = '0, mFl = '0;
  bit done = 0;

  always #5 clk = ~clk;

  canirq_unit i_canirq_unit (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regAddr(regAddr),
    .regWr(regWr), .regMod(regMod), .regRd(regRd), .regWdata(regWdata),
    .regMask(regMask), .opMode(opMode), .regRdata(regRdata),
    .irqN(irqN), .irqCode(irqCode));

  function automatic logic [2:0] expCode(input logic [7:0] p);
    if (p[5]) return 3'b001;
    if (p[6]) return 3'b010;
    if (p[2]) return 3'b011;
    if (p[3]) return 3'b100;
    if (p[4]) return 3'b101;
    if (p[0]) return 3'b110;
    if (p[1]) return 3'b111;
    return 3'b000;
  endfunction

  function automatic logic [7:0] expAcc(input logic [7:0] o, d, m, input logic md);
    return md ? ((o & ~m) | (d & m)) : d;
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] a, input logic rd);
    if (!rd) return 8'h00;
    if (a == A_EN) return mEn;
    if (a == A_FL) return mFl;
    if (a == A_ST) return {opMode, 1'b0, expCode(mFl & mEn), 1'b0};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkPins(input string req);
    chk({req, " R6 pin"}, {7'd0, irqN}, {7'd0, ~(|(mFl & mEn))});
    chk({req, " R7 code"}, {5'd0, irqCode}, {5'd0, expCode(mFl & mEn)});
  endtask

  // drive after a falling edge, check read data, clock once, check pins
  task automatic step(input logic [7:0] ev, input logic [7:0] ad, input logic wr,
                      input logic md, input logic rd, input logic [7:0] wd,
                      input logic [7:0] mk, input string req);
    logic [7:0] nEn, nFl;
    evtPulse = ev; regAddr = ad; regWr = wr; regMod = md; regRd = rd;
    regWdata = wd; regMask = mk;
    #1;
    chk({req, " R8 R9 read"}, regRdata, expRead(ad, rd));
    nEn = mEn; nFl = mFl;
    if ((wr || md) && ad == A_EN) nEn = expAcc(mEn, wd, mk, md);
    if ((wr || md) && ad == A_FL) nFl = expAcc(mFl, wd, mk, md);
    nFl = nFl | ev;
    @(posedge clk);
    mEn = nEn; mFl = nFl;
    @(negedge clk);
    evtPulse = '0; regWr = 0; regMod = 0; regRd = 0;
    chkPins(req);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chkPins("R1");
    regRd = 1; regAddr = A_EN; #1 chk("R1 enables", regRdata, 8'h00);
    regAddr = A_FL; #1 chk("R1 flags", regRdata, 8'h00);
    regRd = 0;
    rstN = 1'b1;
    @(negedge clk);

    // R2 full writes, R4 events, R7 priority walk
    step(8'h00, A_EN, 1, 0, 0, 8'hFF, 8'h00, "R2 enable write");
    step(8'hFF, A_ST, 0, 0, 1, 8'h00, 8'h00, "R4 all events");
    chk("R7 error first", {5'd0, irqCode}, 8'h01);
    step(8'h00, A_FL, 0, 1, 1, 8'h00, 8'h20, "R3 clear error");
    chk("R7 wake next", {5'd0, irqCode}, 8'h02);
    step(8'h00, A_FL, 0, 1, 0, 8'h00, 8'h40, "R3 clear wake");
    chk("R7 tx0 next", {5'd0, irqCode}, 8'h03);
    // R5 collision: clear all flags while pulsing RX1
    step(8'h02, A_FL, 1, 0, 0, 8'h00, 8'h00, "R5 collision");
    chk("R5 rx1 kept", {5'd0, irqCode}, 8'h07);
    // R4 sticky over idle cycles
    step(8'h00, A_ST, 0, 0, 1, 8'h00, 8'h00, "R4 sticky");
    // R10 status write ignored, unmapped write ignored
    step(8'h00, A_ST, 1, 0, 0, 8'h00, 8'h00, "R10 status write");
    step(8'h00, 8'h07, 0, 1, 0, 8'h00, 8'hFF, "R10 unmapped modify");
    step(8'h00, A_EN, 0, 0, 1, 8'h00, 8'h00, "R10 enable read");
    chk("R10 enables intact", regRdata, 8'hFF);
    // R6 message-error only: pin low, code 000
    step(8'h00, A_EN, 1, 1, 0, 8'h80, 8'hFF, "R3 modify wins");
    step(8'h80, A_FL, 1, 0, 0, 8'h00, 8'h00, "R6 merr only");
    chk("R6 merr pin", {7'd0, irqN}, 8'h00);
    chk("R7 merr no code", {5'd0, irqCode}, 8'h00);
    // R9 unmapped read
    step(8'h00, 8'h55, 0, 0, 1, 8'h00, 8'h00, "R9 unmapped read");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ev, ad;
      logic wr, md, rd;
      ev = 8'(($urandom() % 8 == 0) ? (1 << ($urandom() % 8)) : 0);
      ad = 8'($urandom() % 4);
      wr = ($urandom() % 4) == 0;
      md = ($urandom() % 5) == 0;
      rd = $urandom() % 2;
      opMode = 3'($urandom());
      step(ev, ad, wr, md, rd, 8'($urandom()), 8'($urandom()), "R2 R3 R4 R5 R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule